// File: doc/BRIEF.md
# Newton-Raphson Fixed-Point Reciprocal

This block takes an unsigned integer `a` and returns the fixed-point value `2^DATA_W / a`. That value is the reciprocal of `a`, scaled so that it fills an unsigned word of the same width. No divider is used. The block first shifts the operand left until its top bit is set, which places it in [0.5, 1). It takes a starting estimate of the inverse square root from a small table indexed by the bits just below the top bit. It then refines that estimate with `ITERS` Newton steps of the form `y' = y * (3 - m*y*y) / 2`. The refined estimate is squared, which gives the reciprocal of the normalised operand, and the square is shifted back by the normalising distance. All intermediate rounding truncates. A result that does not fit the output word is clamped to all ones.

The parameter `PIPELINED` selects one of two builds:
- With `PIPELINED = 0`, one Newton stage is reused over several cycles. The block takes a new operand only while `inReady` is high.
- With `PIPELINED = 1`, every Newton step has its own stage. The block takes an operand on every cycle.

Both builds have the same latency. A producer drives `inValid` and `inData`. A result appears on `outData` for one cycle, marked by `outValid`.

Top module: `nr_recip`

## Requirements
- R1: For a nonzero operand `a`, `outData` differs by at most 2 from `min(floor(2^DATA_W / a), 2^DATA_W - 1)`.
- R2: An operand of 0 yields `outData` equal to all ones (`2^DATA_W - 1`) exactly.
- R3: An operand of 1, whose exact result `2^DATA_W` does not fit, saturates instead of wrapping. The result lies in `[2^DATA_W - 3, 2^DATA_W - 1]`.
- R4: An operand is accepted at a rising edge where `inValid` and `inReady` are both high. Its result is presented with `outValid` high for one cycle after the edge that comes `ITERS + 1` edges later. This holds in both builds. Every accepted operand produces exactly one result.
- R5: In the shared build, `inReady` goes low after an accepting edge and stays low for `ITERS + 1` cycles. It is high again in the cycle that shows the result. Operands offered while `inReady` is low are ignored: they produce no result and do not change the result in flight.
- R6: In the pipelined build, `inReady` is always high. An operand is taken on every cycle with `inValid` high, and results leave in the order their operands arrived.
- R7: While reset (`rstN` low) is asserted, `outValid` is 0 and `inReady` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operand offered this cycle |
| inData | input | DATA_W | Unsigned operand `a` |
| inReady | output | 1 | Block can take an operand this cycle |
| outValid | output | 1 | Result valid this cycle |
| outData | output | DATA_W | `2^DATA_W / a`, truncated, saturated to all ones |

## Verification
The hardest case to reach is the shared build being offered an operand while it is still working on an earlier one. From the ports, a dropped operand and an operand that leaked into the running iteration look alike, unless the later result is compared against the operand that was actually accepted. The stimulus therefore holds `inValid` high and changes `inData` on every cycle after each directed operand. The bench keeps its own model of when the block is busy, independent of the design. Each result is checked against the operand that model says was taken, while the pipelined instance sees the same stream and has to take every value.

// File: rtl/nr_recip_pkg.sv
package nr_recip_pkg;
  // Strobes from the sequencer to the arithmetic
  typedef struct packed {
    logic load;    // capture a normalised operand and its seed
    logic iter;    // advance one Newton step
    logic finish;  // square, shift back and register the result
  } nrStrobe_t;
endpackage

// File: rtl/nr_recip_ctrl.sv
module nr_recip_ctrl
  import nr_recip_pkg::*;
#(
  parameter int ITERS     = 3,
  parameter bit PIPELINED = 1'b0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  output nrStrobe_t  strobe,
  output logic       outValid
);
  localparam int CW = $clog2(ITERS + 1);

  if (!PIPELINED) begin : g_shared
    logic          busy;
    logic [CW-1:0] cnt;

    always_comb begin
      strobe        = '0;
      strobe.load   = inValid && !busy;
      strobe.iter   = busy && (cnt != CW'(ITERS));
      strobe.finish = busy && (cnt == CW'(ITERS));
    end
    assign inReady = !busy;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        busy     <= 1'b0;
        cnt      <= '0;
        outValid <= 1'b0;
      end else begin
        outValid <= strobe.finish;
        if (strobe.load) begin
          busy <= 1'b1;
          cnt  <= '0;
        end else if (strobe.iter) begin
          cnt <= cnt + CW'(1);
        end else if (strobe.finish) begin
          busy <= 1'b0;
        end
      end
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobe.load, strobe.iter, strobe.finish}));
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
      busy |-> cnt <= CW'(ITERS));
    // R4
    out_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid |=> !outValid);
  end else begin : g_pipe
    logic [ITERS:0] vld;

    always_comb begin
      strobe        = '0;
      strobe.load   = inValid;
      strobe.iter   = 1'b1;
      strobe.finish = vld[ITERS];
    end
    assign inReady = 1'b1;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld      <= '0;
        outValid <= 1'b0;
      end else begin
        vld[0] <= inValid;
        for (int k = 1; k <= ITERS; k++) vld[k] <= vld[k-1];
        outValid <= strobe.finish;
      end
    end
  end
endmodule

// File: rtl/nr_recip_dp.sv
module nr_recip_dp
  import nr_recip_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ITERS     = 3,
  parameter int SEED_BITS = 3,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  nrStrobe_t         strobe,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData
);
  localparam int FB    = DATA_W + 4;           // fraction bits of the estimate
  localparam int YW    = FB + 1;               // estimate width (value below 2)
  localparam int PW    = 2 * FB + DATA_W + 4;  // scratch width for products
  localparam int LZW   = $clog2(DATA_W);
  localparam int NSEED = 1 << SEED_BITS;

  function automatic logic [LZW-1:0] leadZeros(input logic [DATA_W-1:0] v);
    logic [LZW-1:0] n;
    logic found;
    n = '0;
    found = 1'b0;
    for (int b = DATA_W - 1; b >= 0; b--) begin
      if (!found) begin
        if (v[b]) found = 1'b1;
        else      n = n + LZW'(1);
      end
    end
    return n;
  endfunction

  // 1/sqrt of the midpoint of table bin idx, scaled by 2^FB
  function automatic logic [YW-1:0] seedOf(input int idx);
    logic [PW-1:0] q, t;
    logic [YW-1:0] r;
    q = (PW'(1) << (2 * FB + SEED_BITS + 2)) / PW'(2 * NSEED + 2 * idx + 1);
    r = '0;
    for (int b = YW - 1; b >= 0; b--) begin
      t = PW'(r | (YW'(1) << b));
      if (t * t <= q) r = t[YW-1:0];
    end
    return r;
  endfunction

  function automatic logic [YW-1:0] nrStep(input logic [YW-1:0] y,
                                           input logic [DATA_W-1:0] m);
    logic [PW-1:0] yw, sq, prod, three, v;
    yw    = PW'(y);
    sq    = (yw * yw) >> FB;
    prod  = (PW'(m) * sq) >> DATA_W;
    three = PW'(3) << FB;
    v     = (prod > three) ? '0 : three - prod;
    prod  = (yw * v) >> (FB + 1);
    return prod[YW-1:0];
  endfunction

  function automatic logic [DATA_W-1:0] denorm(input logic [YW-1:0] y,
                                               input logic [LZW-1:0] lz,
                                               input logic zero);
    logic [PW-1:0] yw, full;
    yw   = PW'(y);
    full = ((yw * yw) << lz) >> (2 * FB);
    if (zero || full >= (PW'(1) << DATA_W)) return '1;
    return full[DATA_W-1:0];
  endfunction

  logic [YW-1:0] seedTab [NSEED];
  for (genvar i = 0; i < NSEED; i++) begin : g_seed
    localparam logic [YW-1:0] SEEDV = seedOf(i);
    assign seedTab[i] = SEEDV;
  end

  logic              inZero;
  logic [LZW-1:0]    inLz;
  logic [DATA_W-1:0] inNorm;
  logic [YW-1:0]     inSeed;
  logic [DATA_W-1:0] outReg;

  assign inZero  = (inData == '0);
  assign inLz    = leadZeros(inData);
  assign inNorm  = inZero ? {1'b1, {(DATA_W-1){1'b0}}} : (inData << inLz);
  assign inSeed  = seedTab[inNorm[DATA_W-2 -: SEED_BITS]];
  assign outData = outReg;

  if (!PIPELINED) begin : g_shared
    logic [YW-1:0]     yReg;
    logic [DATA_W-1:0] mReg;
    logic [LZW-1:0]    lzReg;
    logic              zReg;

    always_ff @(posedge clk) begin
      if (strobe.load) begin
        yReg  <= inSeed;
        mReg  <= inNorm;
        lzReg <= inLz;
        zReg  <= inZero;
      end else if (strobe.iter) begin
        yReg <= nrStep(yReg, mReg);
      end
      if (strobe.finish) outReg <= denorm(yReg, lzReg, zReg);
    end

    // R2
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.finish && zReg) |=> outData == '1);
  end else begin : g_pipe
    logic [YW-1:0]     yPipe  [ITERS+1];
    logic [DATA_W-1:0] mPipe  [ITERS+1];
    logic [LZW-1:0]    lzPipe [ITERS+1];
    logic              zPipe  [ITERS+1];

    always_ff @(posedge clk) begin
      if (strobe.load) begin
        yPipe[0]  <= inSeed;
        mPipe[0]  <= inNorm;
        lzPipe[0] <= inLz;
        zPipe[0]  <= inZero;
      end
      for (int k = 1; k <= ITERS; k++) begin
        if (strobe.iter) begin
          yPipe[k]  <= nrStep(yPipe[k-1], mPipe[k-1]);
          mPipe[k]  <= mPipe[k-1];
          lzPipe[k] <= lzPipe[k-1];
          zPipe[k]  <= zPipe[k-1];
        end
      end
      if (strobe.finish) outReg <= denorm(yPipe[ITERS], lzPipe[ITERS], zPipe[ITERS]);
    end

    // R2
    zero_sat_chk: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.finish && zPipe[ITERS]) |=> outData == '1);
  end
endmodule

// File: rtl/nr_recip.sv
module nr_recip
  import nr_recip_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ITERS     = 3,
  parameter int SEED_BITS = 3,
  parameter bit PIPELINED = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [DATA_W-1:0] outData
);
  nrStrobe_t strobe;

  nr_recip_ctrl #(.ITERS(ITERS), .PIPELINED(PIPELINED)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .strobe(strobe), .outValid(outValid)
  );

  nr_recip_dp #(.DATA_W(DATA_W), .ITERS(ITERS), .SEED_BITS(SEED_BITS),
                .PIPELINED(PIPELINED)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData), .outData(outData)
  );

  if (!PIPELINED) begin : g_shared_chk
    // R5
    accept_block_chk: assert property (@(posedge clk) disable iff (!rstN)
      (inValid && inReady) |=> !inReady);
  end
endmodule

// File: tb/tb_nr_recip.sv
`timescale 1ns/1ps
module tb_nr_recip;
  localparam int W     = 16;
  localparam int ITERS = 3;
  localparam int LAT   = ITERS + 1;
  localparam int TOL   = 2;
  localparam int MAXV  = (1 << W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [W-1:0] inData = '0;
  logic         rdyA, vA, rdyB, vB;
  logic [W-1:0] dA, dB;

  nr_recip #(.DATA_W(W), .ITERS(ITERS), .PIPELINED(1'b0)) dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(rdyA), .outValid(vA), .outData(dA));
  nr_recip #(.DATA_W(W), .ITERS(ITERS), .PIPELINED(1'b1)) dutPipe (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .inReady(rdyB), .outValid(vB), .outData(dB));

  int nChecks = 0, nFails = 0;
  bit done = 1'b0;
  int cyc = 0;
  int busyUntil = 0;
  int qVal [2][$];
  int qDue [2][$];
  logic [15:0] lfsr = 16'hACE1;

  function automatic int idealOf(int a);
    int q;
    if (a == 0) return MAXV;
    q = (1 << W) / a;
    return (q > MAXV) ? MAXV : q;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic checkOut(int k, logic v, logic [W-1:0] d);
    bit expV;
    string nm;
    nm = (k == 0) ? "shared" : "pipelined";
    expV = (qDue[k].size() > 0) && (qDue[k][0] == cyc);
    if (v || expV) begin
      chk(v == expV, "R4", {nm, " outValid"}, int'(v), int'(expV));
      if (v && expV) begin
        int a, e, diff;
        a = qVal[k][0];
        e = idealOf(a);
        diff = int'(d) - e;
        if (a == 0)      chk(int'(d) == e, "R2", {nm, " zero operand"}, int'(d), e);
        else if (a == 1) chk(diff <= 0 && diff >= -TOL, "R3", {nm, " saturation"}, int'(d), e);
        else             chk(diff <= TOL && diff >= -TOL, "R1", {nm, " accuracy"}, int'(d), e);
      end
      if (expV) begin
        void'(qVal[k].pop_front());
        void'(qDue[k].pop_front());
      end
    end
  endtask

  task automatic step(bit v, logic [W-1:0] d);
    bit expRdy;
    @(negedge clk);
    cyc++;
    checkOut(0, vA, dA);
    checkOut(1, vB, dB);
    expRdy = (cyc >= busyUntil);
    chk(rdyA == expRdy, "R5", "shared inReady", int'(rdyA), int'(expRdy));
    chk(rdyB == 1'b1, "R6", "pipelined inReady", int'(rdyB), 1);
    inValid = v;
    inData  = d;
    if (v && expRdy) begin
      qVal[0].push_back(int'(d));
      qDue[0].push_back(cyc + 1 + LAT);
      busyUntil = cyc + 1 + LAT;
    end
    if (v) begin
      qVal[1].push_back(int'(d));
      qDue[1].push_back(cyc + 1 + LAT);
    end
  endtask

  task automatic lfsrStep();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    int dirVals [12] = '{0, 1, 2, 3, 4, 255, 256, 1000, 32767, 32768, 65534, 65535};
    // R7: reset state
    repeat (3) begin
      @(negedge clk);
      chk(vA == 1'b0, "R7", "shared outValid in reset", int'(vA), 0);
      chk(vB == 1'b0, "R7", "pipelined outValid in reset", int'(vB), 0);
      chk(rdyA == 1'b1, "R7", "shared inReady in reset", int'(rdyA), 1);
    end
    rstN = 1'b1;
    // Directed operands, each followed by changing junk while the shared unit is busy (R5)
    for (int i = 0; i < 12; i++) begin
      step(1'b1, W'(dirVals[i]));
      for (int j = 0; j < LAT; j++) step(1'b1, W'(dirVals[i]) ^ W'(16'hA5A5 + j));
    end
    // Back-to-back stream: pipelined takes every value in order (R6)
    for (int i = 0; i < 400; i++) begin
      lfsrStep();
      step(1'b1, lfsr);
    end
    // Irregular valid pattern
    for (int i = 0; i < 400; i++) begin
      lfsrStep();
      step(lfsr[3], lfsr ^ 16'h3C5A);
    end
    for (int i = 0; i < 2 * LAT + 4; i++) step(1'b0, '0);
    chk(qVal[0].size() == 0, "R4", "shared results outstanding", qVal[0].size(), 0);
    chk(qVal[1].size() == 0, "R4", "pipelined results outstanding", qVal[1].size(), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R4 watchdog expired actual=%0d expected=%0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule